// File: doc/BRIEF.md
# I2C Status Flag Register Controller

This block keeps the two status registers of an I2C peripheral and enforces the rules by which each flag is set and cleared. A protocol engine, which is outside this block, reports bus events as one-cycle set pulses and supplies the level-type bits. Software reaches the status, control, data and interrupt-enable registers through a simple single-cycle register port. The block produces two gated interrupt lines and a 32-bit event word, and it compares that word against a requested event pattern.

Error flags are cleared by writing zero to their bit in status register 1. Protocol flags are never cleared by a direct write. Each one is cleared only by an ordered pair of accesses: a status-1 read, then a particular second access.

The ordering is tracked by a two-state sequencer. In `SEQ_IDLE`, a status-1 read takes the ARM transition to `SEQ_ARMED`, and at the same moment the sequencer captures which protocol flags are set. Any other access in `SEQ_IDLE` is a NOP transition that stays in `SEQ_IDLE`. In `SEQ_ARMED`, another status-1 read takes the REARM transition: the sequencer stays armed and captures the flags again. Any other access takes the CONSUME transition back to `SEQ_IDLE`. During CONSUME, the armed flags that this access qualifies for are cleared.

Top module: `i2c_status_ctrl`

## Requirements
- R1: After reset, both status registers, control register 1, the enable register, the data register, both interrupt outputs and the event word are all zero.
- R2: A `set_pulse` bit in status-1 position 0–4, 8–12, 14 or 15 sets that flag at the next clock edge. Status-1 bit 6 (receive full) follows `lvl_buf[0]` and bit 7 (transmit empty) follows `lvl_buf[1]`. Status-2 bits follow `lvl_s2`. Each level bit takes its input with a delay of one cycle.
- R3: The start flag (status-1 bit 0) is cleared by a status-1 read (offset 0x14) followed by a data-register write (offset 0x10).
- R4: The address flag (status-1 bit 1) is cleared by a status-1 read followed by a status-2 read (offset 0x18).
- R5: The byte-finished flag (status-1 bit 2) is cleared by a status-1 read followed by either a data-register read or a data-register write.
- R6: The stop flag (status-1 bit 4) is cleared by a status-1 read followed by a write to control register 1 (offset 0x00).
- R7: The 10-bit-header flag (status-1 bit 3) is cleared by a status-1 read followed by a data-register write.
- R8: The following leave the protocol flags (status-1 bits 0–4) unchanged:
  - any write to status 1;
  - a qualifying second access that has no status-1 read before it;
  - a qualifying access that comes after an intervening non-qualifying access, such as a write to the enable register (offset 0x04).
- R9: The error flags (status-1 bits 8–12, 14 and 15) are cleared by writing 0 to their bit in status 1. A bit written as 1 leaves its flag unchanged.
- R10: A sequence clears only the flags that were set when its status-1 read happened. A flag set after that read survives the second access.
- R11: When a set pulse and a clear act on the same flag in the same cycle, the flag stays set.
- R12: The interrupt outputs are gated by the enable register:
  - `irq_err` is high when any error flag is set and enable bit 0 is set.
  - `irq_evt` is high when enable bit 1 is set and either a protocol flag is set, or enable bit 2 is set and status-1 bit 6 or bit 7 is set.
- R13: `evt_word` carries status 1 in bits 15:0 and status 2 in bits 31:16. `evt_match` is high exactly when every bit set in `evt_query` is also set in `evt_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register (combinational) |
| set_pulse | input | 16 | One-cycle set pulses, in status-1 bit positions |
| lvl_buf | input | 2 | Receive-full (bit 0) and transmit-empty (bit 1) levels |
| lvl_s2 | input | S2_W | Status-2 level bits |
| ctl1_o | output | 16 | Control register 1 contents |
| tx_data | output | DATA_W | Data register contents |
| irq_evt | output | 1 | Gated event/buffer interrupt |
| irq_err | output | 1 | Gated error interrupt |
| evt_word | output | 32 | Combined event word |
| evt_query | input | 32 | Requested event pattern |
| evt_match | output | 1 | All bits of `evt_query` are present in `evt_word` |

## Verification
Every protocol flag is driven through its own qualifying pair of accesses. These runs are mixed with three kinds of non-clearing access: the second access on its own, a direct write to status 1, and a pair broken by an unrelated access. Comparing the two groups shows whether clearing depends on order rather than on address alone.

One case sets a flag after the status-1 read. Another lands a set pulse in the same cycle as a clear. Together they separate a capture-at-read arm from a clear-whatever-is-set-now arm, and set priority from clear priority.

The error bits are written with all-ones, then with a single zero, then with all-zeros. This shows that clearing is per bit and that a written 1 has no effect.

## Assertions
The assertions live in `rtl/i2c_sf_checker.sv`, which is bound to the top module.

// File: rtl/i2c_sf_pkg.sv
package i2c_sf_pkg;

    localparam int SR_W = 16;

    localparam logic [7:0] OFF_CTL1  = 8'h00;
    localparam logic [7:0] OFF_IEN   = 8'h04;
    localparam logic [7:0] OFF_DATA  = 8'h10;
    localparam logic [7:0] OFF_STAT1 = 8'h14;
    localparam logic [7:0] OFF_STAT2 = 8'h18;

    // status-1 bit groups
    localparam logic [SR_W-1:0] PROTO_MASK = 16'h001F;
    localparam logic [SR_W-1:0] ERR_MASK   = 16'hDF00;
    localparam logic [SR_W-1:0] BUF_MASK   = 16'h00C0;
    localparam int              BUF_LSB    = 6;

    // protocol flags each second access may clear
    localparam logic [SR_W-1:0] Q_DATA_WR  = 16'h000D;
    localparam logic [SR_W-1:0] Q_DATA_RD  = 16'h0004;
    localparam logic [SR_W-1:0] Q_STAT2_RD = 16'h0002;
    localparam logic [SR_W-1:0] Q_CTL1_WR  = 16'h0010;

    // enable-register bits
    localparam int IE_W   = 3;
    localparam int IE_ERR = 0;
    localparam int IE_EVT = 1;
    localparam int IE_BUF = 2;

    typedef enum logic [1:0] {
        BK_RSVD,
        BK_SEQ,
        BK_ERR,
        BK_LEVEL
    } bit_kind_t;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_ARMED
    } seq_state_t;

    function automatic bit_kind_t kind_of(input int idx);
        if (PROTO_MASK[idx])     return BK_SEQ;
        else if (ERR_MASK[idx])  return BK_ERR;
        else if (BUF_MASK[idx])  return BK_LEVEL;
        else                     return BK_RSVD;
    endfunction

endpackage

// File: rtl/i2c_sf_seq.sv
module i2c_sf_seq
    import i2c_sf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc,
    input  logic            s1_rd,
    input  logic            s2_rd,
    input  logic            dat_rd,
    input  logic            dat_wr,
    input  logic            c1_wr,
    input  logic [SR_W-1:0] stat1,
    output logic [SR_W-1:0] clr_mask,
    output logic            armed
);

    seq_state_t      state_q, state_d;
    logic [SR_W-1:0] arm_q, arm_d;
    logic [SR_W-1:0] qual;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            arm_q   <= '0;
        end else begin
            state_q <= state_d;
            arm_q   <= arm_d;
        end
    end

    // transitions and outputs
    always_comb begin
        qual = '0;
        if (dat_wr) qual = qual | Q_DATA_WR;
        if (dat_rd) qual = qual | Q_DATA_RD;
        if (s2_rd)  qual = qual | Q_STAT2_RD;
        if (c1_wr)  qual = qual | Q_CTL1_WR;

        state_d  = state_q;
        arm_d    = arm_q;
        clr_mask = '0;
        armed    = (state_q == SEQ_ARMED);

        unique case (state_q)
            SEQ_IDLE: begin
                if (s1_rd) begin                 // ARM
                    state_d = SEQ_ARMED;
                    arm_d   = stat1 & PROTO_MASK;
                end
            end
            SEQ_ARMED: begin
                if (s1_rd) begin                 // REARM
                    arm_d = stat1 & PROTO_MASK;
                end else if (acc) begin          // CONSUME
                    clr_mask = arm_q & qual;
                    state_d  = SEQ_IDLE;
                    arm_d    = '0;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

endmodule

// File: rtl/i2c_sf_flags.sv
module i2c_sf_flags
    import i2c_sf_pkg::*;
#(
    parameter int S2_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SR_W-1:0] set_pulse,
    input  logic [1:0]      lvl_buf,
    input  logic [S2_W-1:0] lvl_s2,
    input  logic [SR_W-1:0] seq_clr,
    input  logic            err_wr,
    input  logic [SR_W-1:0] err_wdata,
    output logic [SR_W-1:0] stat1,
    output logic [S2_W-1:0] stat2
);

    for (genvar i = 0; i < SR_W; i++) begin : g_bit
        if (kind_of(i) == BK_SEQ) begin : g_seq
            always_ff @(posedge clk) begin
                if (!rst_n) stat1[i] <= 1'b0;
                else        stat1[i] <= set_pulse[i] | (stat1[i] & ~seq_clr[i]);
            end
        end else if (kind_of(i) == BK_ERR) begin : g_err
            logic wclr;
            assign wclr = err_wr & ~err_wdata[i];
            always_ff @(posedge clk) begin
                if (!rst_n) stat1[i] <= 1'b0;
                else        stat1[i] <= set_pulse[i] | (stat1[i] & ~wclr);
            end
        end else if (kind_of(i) == BK_LEVEL) begin : g_lvl
            always_ff @(posedge clk) begin
                if (!rst_n) stat1[i] <= 1'b0;
                else        stat1[i] <= lvl_buf[i-BUF_LSB];
            end
        end else begin : g_rsvd
            assign stat1[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat2 <= '0;
        else        stat2 <= lvl_s2;
    end

endmodule

// File: rtl/i2c_sf_irq.sv
module i2c_sf_irq
    import i2c_sf_pkg::*;
#(
    parameter int S2_W = 8
) (
    input  logic [SR_W-1:0]   stat1,
    input  logic [S2_W-1:0]   stat2,
    input  logic [IE_W-1:0]   ien,
    input  logic [2*SR_W-1:0] query,
    output logic              irq_evt,
    output logic              irq_err,
    output logic [2*SR_W-1:0] word,
    output logic              match
);

    logic any_err, any_proto, any_buf;

    always_comb begin
        any_err   = |(stat1 & ERR_MASK);
        any_proto = |(stat1 & PROTO_MASK);
        any_buf   = |(stat1 & BUF_MASK);
        irq_err   = ien[IE_ERR] & any_err;
        irq_evt   = ien[IE_EVT] & (any_proto | (ien[IE_BUF] & any_buf));
        word      = {SR_W'(stat2), stat1};
        match     = ((word & query) == query);
    end

endmodule

// File: rtl/i2c_status_ctrl.sv
module i2c_status_ctrl
    import i2c_sf_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int S2_W   = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [15:0]       set_pulse,
    input  logic [1:0]        lvl_buf,
    input  logic [S2_W-1:0]   lvl_s2,
    output logic [15:0]       ctl1_o,
    output logic [DATA_W-1:0] tx_data,
    output logic              irq_evt,
    output logic              irq_err,
    output logic [31:0]       evt_word,
    input  logic [31:0]       evt_query,
    output logic              evt_match
);

    localparam logic [ADDR_W-1:0] A_CTL1  = ADDR_W'(OFF_CTL1);
    localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFF_IEN);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_STAT1 = ADDR_W'(OFF_STAT1);
    localparam logic [ADDR_W-1:0] A_STAT2 = ADDR_W'(OFF_STAT2);

    logic [SR_W-1:0]   stat1_q;
    logic [S2_W-1:0]   stat2_q;
    logic [SR_W-1:0]   seq_clr;
    logic              seq_armed;
    logic [15:0]       ctl1_q;
    logic [IE_W-1:0]   ctl2_q;
    logic [DATA_W-1:0] data_q;

    logic rd_en, wr_en;
    logic s1_rd, s2_rd, dat_rd, dat_wr, c1_wr, ie_wr, s1_wr;

    always_comb begin
        rd_en  = reg_req & ~reg_wr;
        wr_en  = reg_req &  reg_wr;
        s1_rd  = rd_en & (reg_addr == A_STAT1);
        s2_rd  = rd_en & (reg_addr == A_STAT2);
        dat_rd = rd_en & (reg_addr == A_DATA);
        dat_wr = wr_en & (reg_addr == A_DATA);
        c1_wr  = wr_en & (reg_addr == A_CTL1);
        ie_wr  = wr_en & (reg_addr == A_IEN);
        s1_wr  = wr_en & (reg_addr == A_STAT1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl1_q <= '0;
            ctl2_q <= '0;
            data_q <= '0;
        end else begin
            if (c1_wr)  ctl1_q <= reg_wdata;
            if (ie_wr)  ctl2_q <= reg_wdata[IE_W-1:0];
            if (dat_wr) data_q <= reg_wdata[DATA_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTL1:  reg_rdata = ctl1_q;
            A_IEN:   reg_rdata = 16'(ctl2_q);
            A_DATA:  reg_rdata = 16'(data_q);
            A_STAT1: reg_rdata = stat1_q;
            A_STAT2: reg_rdata = 16'(stat2_q);
            default: reg_rdata = '0;
        endcase
    end

    i2c_sf_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (reg_req),
        .s1_rd    (s1_rd),
        .s2_rd    (s2_rd),
        .dat_rd   (dat_rd),
        .dat_wr   (dat_wr),
        .c1_wr    (c1_wr),
        .stat1    (stat1_q),
        .clr_mask (seq_clr),
        .armed    (seq_armed)
    );

    i2c_sf_flags #(.S2_W(S2_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (set_pulse),
        .lvl_buf   (lvl_buf),
        .lvl_s2    (lvl_s2),
        .seq_clr   (seq_clr),
        .err_wr    (s1_wr),
        .err_wdata (reg_wdata),
        .stat1     (stat1_q),
        .stat2     (stat2_q)
    );

    i2c_sf_irq #(.S2_W(S2_W)) u_irq (
        .stat1   (stat1_q),
        .stat2   (stat2_q),
        .ien     (ctl2_q),
        .query   (evt_query),
        .irq_evt (irq_evt),
        .irq_err (irq_err),
        .word    (evt_word),
        .match   (evt_match)
    );

    assign ctl1_o  = ctl1_q;
    assign tx_data = data_q;

endmodule

// File: rtl/i2c_sf_checker.sv
module i2c_sf_checker
    import i2c_sf_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       set_pulse,
    input logic [15:0]       stat1_q,
    input logic              seq_armed,
    input logic [IE_W-1:0]   ctl2_q,
    input logic              irq_err,
    input logic [31:0]       evt_query,
    input logic              evt_match
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $rose(rst_n) |-> (stat1_q == '0)) else $error("AST_RESET_CLEARS");              // R1

    AST_SEQ_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse[0] |=> stat1_q[0]) else $error("AST_SEQ_PULSE_WINS");                  // R11

    AST_ERR_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse[8] |=> stat1_q[8]) else $error("AST_ERR_PULSE_WINS");                  // R2

    AST_PROTO_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat1_q[1]) |-> $past(seq_armed)) else $error("AST_PROTO_CLEAR_NEEDS_ARM"); // R8

    AST_ERR_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_wr && reg_addr == ADDR_W'(OFF_STAT1) && reg_wdata[9] && stat1_q[9])
        |=> stat1_q[9]) else $error("AST_ERR_ONE_KEEPS");                                // R9

    AST_ERR_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl2_q[IE_ERR] |-> !irq_err) else $error("AST_ERR_IRQ_GATED");                  // R12

    AST_EMPTY_QUERY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_query == '0) |-> evt_match) else $error("AST_EMPTY_QUERY_MATCHES");         // R13

endmodule

bind i2c_status_ctrl i2c_sf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_req   (reg_req),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .set_pulse (set_pulse),
    .stat1_q   (stat1_q),
    .seq_armed (seq_armed),
    .ctl2_q    (ctl2_q),
    .irq_err   (irq_err),
    .evt_query (evt_query),
    .evt_match (evt_match)
);

// File: tb/i2c_status_ctrl_bench.sv
module i2c_status_ctrl_bench;

    localparam logic [4:0] A_CTL1  = 5'h00;
    localparam logic [4:0] A_IEN   = 5'h04;
    localparam logic [4:0] A_DATA  = 5'h10;
    localparam logic [4:0] A_STAT1 = 5'h14;
    localparam logic [4:0] A_STAT2 = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] set_pulse = '0;
    logic [1:0]  lvl_buf = '0;
    logic [7:0]  lvl_s2 = '0;
    logic [15:0] ctl1_o;
    logic [7:0]  tx_data;
    logic        irq_evt, irq_err;
    logic [31:0] evt_word;
    logic [31:0] evt_query = '0;
    logic        evt_match;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;
    logic [15:0] rd;

    always #5 clk = ~clk;

    i2c_status_ctrl u_i2c_status_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .set_pulse(set_pulse), .lvl_buf(lvl_buf), .lvl_s2(lvl_s2),
        .ctl1_o(ctl1_o), .tx_data(tx_data), .irq_evt(irq_evt), .irq_err(irq_err),
        .evt_word(evt_word), .evt_query(evt_query), .evt_match(evt_match)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access, optionally with set pulses in the same cycle
    task automatic bus(input logic wr, input logic [4:0] a, input logic [15:0] d,
                       input logic [15:0] pls, output logic [15:0] rdat);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = wr; reg_addr = a; reg_wdata = d; set_pulse = pls;
        #1 rdat = reg_rdata;
        @(negedge clk);
        reg_req = 1'b0; reg_wr = 1'b0; set_pulse = '0;
    endtask

    task automatic pulse(input logic [15:0] pls);
        @(negedge clk);
        set_pulse = pls;
        @(negedge clk);
        set_pulse = '0;
    endtask

    task automatic t_reset;
        check("R1 stat", evt_word, 32'h0);
        check("R1 irq", {30'd0, irq_evt, irq_err}, 32'h0);
        check("R1 ctl1/data", {ctl1_o, 8'd0, tx_data}, 32'h0);
        bus(1'b0, A_IEN, 16'h0, 16'h0, rd);
        check("R1 ien", {16'd0, rd}, 32'h0);
    endtask

    task automatic t_start;
        pulse(16'h0001);
        check("R2 start set", evt_word, 32'h0000_0001);
        bus(1'b1, A_DATA, 16'h00A5, 16'h0, rd);
        check("R8 data wr alone", evt_word, 32'h0000_0001);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        check("R3 stat1 read value", {16'd0, rd}, 32'h0000_0001);
        bus(1'b1, A_DATA, 16'h005A, 16'h0, rd);
        check("R3 start cleared", evt_word, 32'h0);
        check("R3 data stored", {24'd0, tx_data}, 32'h5A);
    endtask

    task automatic t_addr;
        pulse(16'h0002);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        bus(1'b0, A_STAT2, 16'h0, 16'h0, rd);
        check("R4 addr cleared", evt_word, 32'h0);
        pulse(16'h0002);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        bus(1'b1, A_IEN, 16'h0, 16'h0, rd);
        bus(1'b0, A_STAT2, 16'h0, 16'h0, rd);
        check("R8 broken pair", evt_word, 32'h0000_0002);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        bus(1'b0, A_STAT2, 16'h0, 16'h0, rd);
        check("R4 cleanup", evt_word, 32'h0);
    endtask

    task automatic t_btf;
        pulse(16'h0004);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        bus(1'b0, A_DATA, 16'h0, 16'h0, rd);
        check("R5 byte done rd clear", evt_word, 32'h0);
        pulse(16'h0004);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        bus(1'b1, A_DATA, 16'h0011, 16'h0, rd);
        check("R5 byte done wr clear", evt_word, 32'h0);
    endtask

    task automatic t_stop;
        pulse(16'h0010);
        bus(1'b1, A_STAT1, 16'h0000, 16'h0, rd);
        check("R8 direct write", evt_word, 32'h0000_0010);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        bus(1'b1, A_CTL1, 16'h0001, 16'h0, rd);
        check("R6 stop cleared", evt_word, 32'h0);
        check("R6 ctl1 stored", {16'd0, ctl1_o}, 32'h0001);
    endtask

    task automatic t_hdr;
        pulse(16'h0008);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        bus(1'b1, A_DATA, 16'h00F0, 16'h0, rd);
        check("R7 hdr cleared", evt_word, 32'h0);
    endtask

    task automatic t_late;
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        pulse(16'h0004);
        bus(1'b0, A_DATA, 16'h0, 16'h0, rd);
        check("R10 late flag kept", evt_word, 32'h0000_0004);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        bus(1'b0, A_DATA, 16'h0, 16'h0, rd);
        check("R10 cleanup", evt_word, 32'h0);
    endtask

    task automatic t_collide;
        pulse(16'h0001);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        bus(1'b1, A_DATA, 16'h0, 16'h0001, rd);
        check("R11 seq set wins", evt_word, 32'h0000_0001);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        bus(1'b1, A_DATA, 16'h0, 16'h0, rd);
        pulse(16'h0100);
        bus(1'b1, A_STAT1, 16'h0000, 16'h0100, rd);
        check("R11 err set wins", evt_word, 32'h0000_0100);
        bus(1'b1, A_STAT1, 16'h0000, 16'h0, rd);
        check("R11 cleanup", evt_word, 32'h0);
    endtask

    task automatic t_err;
        pulse(16'hDF00);
        check("R2 err set", evt_word, 32'h0000_DF00);
        bus(1'b1, A_STAT1, 16'hFFFF, 16'h0, rd);
        check("R9 ones keep", evt_word, 32'h0000_DF00);
        bus(1'b1, A_STAT1, 16'hFEFF, 16'h0, rd);
        check("R9 single clear", evt_word, 32'h0000_DE00);
        bus(1'b1, A_STAT1, 16'h0000, 16'h0, rd);
        check("R9 all clear", evt_word, 32'h0);
    endtask

    task automatic t_irq;
        pulse(16'h0200);
        check("R12 err masked", {31'd0, irq_err}, 32'h0);
        bus(1'b1, A_IEN, 16'h0001, 16'h0, rd);
        check("R12 err enabled", {31'd0, irq_err}, 32'h1);
        bus(1'b1, A_STAT1, 16'h0000, 16'h0, rd);
        check("R12 err gone", {31'd0, irq_err}, 32'h0);
        @(negedge clk); lvl_buf = 2'b01;
        bus(1'b1, A_IEN, 16'h0002, 16'h0, rd);
        check("R2 rx level", evt_word, 32'h0000_0040);
        check("R12 buf masked", {31'd0, irq_evt}, 32'h0);
        bus(1'b1, A_IEN, 16'h0006, 16'h0, rd);
        check("R12 buf enabled", {31'd0, irq_evt}, 32'h1);
        @(negedge clk); lvl_buf = 2'b00;
        bus(1'b1, A_IEN, 16'h0002, 16'h0, rd);
        pulse(16'h0001);
        check("R12 proto evt", {31'd0, irq_evt}, 32'h1);
        bus(1'b0, A_STAT1, 16'h0, 16'h0, rd);
        bus(1'b1, A_DATA, 16'h0, 16'h0, rd);
        check("R12 evt gone", {31'd0, irq_evt}, 32'h0);
        bus(1'b1, A_IEN, 16'h0000, 16'h0, rd);
    endtask

    task automatic t_event;
        @(negedge clk); lvl_s2 = 8'h03;
        pulse(16'h0001);
        check("R13 word", evt_word, 32'h0003_0001);
        evt_query = 32'h0003_0001; #1;
        check("R13 full match", {31'd0, evt_match}, 32'h1);
        evt_query = 32'h0007_0001; #1;
        check("R13 extra bit", {31'd0, evt_match}, 32'h0);
        evt_query = 32'h0; #1;
        check("R13 empty query", {31'd0, evt_match}, 32'h1);
        bus(1'b0, A_STAT2, 16'h0, 16'h0, rd);
        check("R2 stat2 read", {16'd0, rd}, 32'h0003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_start;
        t_addr;
        t_btf;
        t_stop;
        t_hdr;
        t_late;
        t_collide;
        t_err;
        t_irq;
        t_event;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule